// File: doc/BRIEF.md
# Mapped Multi-Channel Event Scaler

The scaler counts events on four 32-bit counters. Eight external event lines enter through a synchronizer. Programmable masks decide three things: which lines feed each counter, which lines take a snapshot, and which lines toggle the running state. Each counter adds one on every rising edge of the OR of the lines selected for it, and only while the scaler is running. A snapshot copies all four counter values at once into an eight-entry circular buffer.

Software drains the buffer one snapshot at a time. A command in the control word moves the oldest snapshot into an output holding register. Successive reads of that register then return counter 0, 1, 2 and 3 in turn. Software can also copy the live counts straight into the holding register, peek at the oldest buffered snapshot, and read the live counters. The full-scale value at which every counter wraps is programmable.

The bus is a pipelined Wishbone slave with one 32-bit word per address. It never stalls and acknowledges each request in the following cycle.

Top module: `evt_scaler`

## Requirements
- R1: After reset, the registers read as follows: control 0x00000001, counter map 0x08040201 (counter n counts line n), latch map 0x00000010, run map 0x00000080, full-scale 0xFFFFFFFF. Word offsets are 0 control, 1 counter map, 2 latch map, 3 run map, 4 live view, 5 peek view, 6 output, 7 full-scale.
- R2: Every request with cyc and stb high is acknowledged exactly one cycle later. Stall is never raised.
- R3: Counter n adds one per rising edge of the OR of the synchronized lines selected by counter-map bits 8n+7:8n, and only while running. It holds its value while stopped.
- R4: Control bit 3 reads as running. Writing 1 to bit 3 starts and writing 1 to bit 4 stops, with stop winning when both are written; both are ignored unless run-map bit 8 is set. A rising edge of the OR of the lines selected by run-map bits 7:0 toggles running.
- R5: A rising edge of the OR of the lines selected by latch-map bits 7:0, or a write of 1 to control bit 7 while latch-map bit 8 is set, pushes one snapshot of all four counters. The snapshot is dropped when eight are already held.
- R6: Control bit 0 reads buffer empty, bit 1 buffer full (8 held) and bit 2 threshold (4 or more held).
- R7: Writing 1 to control bit 6 moves the oldest snapshot into the output register. When the buffer is empty the command does nothing, and the output register and its read position are untouched.
- R8: Successive reads of offset 6 return output words for counter 0, 1, 2, 3 and then wrap. Every load of the output register restarts the sequence at counter 0.
- R9: Writing 1 to control bit 5 copies the live counts into the output register.
- R10: Writing 1 to control bit 0 clears all four counters and their overflow flags.
- R11: A counter that increments from the full-scale value (offset 7) wraps to 0 and sets sticky control bit 8+n.
- R12: Control bit 12 reads back as written. While it is set, every latch event also copies the live counts into the output register.
- R13: Successive reads of offset 4 return the live counts of counter 0..3 cyclically, starting at 0 after a counter clear. Reads of offset 5 return the words of the oldest buffered snapshot in the same way, starting at 0 after each pop, and read 0 when the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wb_cyc_i | input | 1 | Bus cycle valid |
| wb_stb_i | input | 1 | Request strobe |
| wb_we_i | input | 1 | Write enable |
| wb_adr_i | input | 3 | Word offset |
| wb_dat_i | input | 32 | Write data |
| wb_dat_o | output | 32 | Read data, valid with ack |
| wb_ack_o | output | 1 | Acknowledge |
| wb_stall_o | output | 1 | Stall, always low |
| ev_in_i | input | 8 | Asynchronous event lines |

## Verification
The hardest conditions to reach from the ports are a buffer at capacity with one more latch arriving, and a counter wrapping past its full-scale value. The stimulus gets to the first by issuing software latches until the buffer holds eight snapshots, adding a ninth, and then popping until the empty flag returns after exactly eight pops. It gets to the second by lowering the full-scale register to 2, so that three line pulses produce the wrap and the sticky flag. An empty-buffer pop is placed after a partial read of the output register, so that a wrong restart of the read position would show up in the next word.

// File: rtl/evs_pkg.sv
// Shared constants and register offsets for the event scaler.
// Assumes a fixed four-channel layout: one byte of input mask per counter.
package evs_pkg;
    localparam int EVS_NCH = 4;
    localparam int EVS_NIN = 8;
    localparam int EVS_CW  = 32;

    typedef enum logic [2:0] {
        RA_CTRL  = 3'd0,
        RA_CMAP  = 3'd1,
        RA_LMAP  = 3'd2,
        RA_SMAP  = 3'd3,
        RA_LIVE  = 3'd4,
        RA_PEEK  = 3'd5,
        RA_OUT   = 3'd6,
        RA_LIMIT = 3'd7
    } reg_addr_e;

    localparam int CB_EMPTY = 0;
    localparam int CB_FULL  = 1;
    localparam int CB_THR   = 2;
    localparam int CB_RUN   = 3;
    localparam int CB_STOP  = 4;
    localparam int CB_LDCUR = 5;
    localparam int CB_LDBUF = 6;
    localparam int CB_SWLAT = 7;
    localparam int CB_OVF   = 8;
    localparam int CB_AUTO  = 12;
    localparam int SW_BIT   = 8;
endpackage

// File: rtl/evs_sync.sv
// Multi-stage synchronizer bank for asynchronous event lines.
// Assumes every line is independent; no glitch filtering is done.
module evs_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg [STAGES];

    // Shift each line through the register chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= '0;
        end else begin
            stg[0] <= d_i;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/evs_counter.sv
// One event counter with programmable full-scale wrap and sticky overflow.
// Assumes inc_i is already gated by the run state; clr_i has priority.
module evs_counter #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          inc_i,
    input  logic [CW-1:0] limit_i,
    output logic [CW-1:0] count_o,
    output logic          ovf_o
);
    // Count, wrap at the full-scale value, clear on request.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            count_o <= '0;
            ovf_o   <= 1'b0;
        end else if (inc_i) begin
            if (count_o == limit_i) begin
                count_o <= '0;
                ovf_o   <= 1'b1;
            end else begin
                count_o <= count_o + 1'b1;
            end
        end
    end

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (count_o == '0 && !ovf_o)); // R10
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !inc_i) |=> $stable(count_o)); // R3
    AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && inc_i && count_o == limit_i) |=> (ovf_o && count_o == '0)); // R11
endmodule

// File: rtl/evs_snapfifo.sv
// Circular buffer of counter snapshots with empty/full/threshold flags.
// Assumes a push while full is dropped even if a pop happens in the same cycle.
module evs_snapfifo #(
    parameter int W      = 128,
    parameter int DEPTH  = 8,
    parameter int THRESH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] data_i,
    input  logic         pop_i,
    output logic [W-1:0] head_o,
    output logic         empty_o,
    output logic         full_o,
    output logic         thr_o
);
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0]   LAST  = AW'(DEPTH - 1);
    localparam logic [CNTW-1:0] DFULL = CNTW'(DEPTH);
    localparam logic [CNTW-1:0] DTHR  = CNTW'(THRESH);

    logic [W-1:0]    mem [DEPTH];
    logic [AW-1:0]   wr_ptr, rd_ptr;
    logic [CNTW-1:0] fill;
    logic            do_push, do_pop;

    assign empty_o = (fill == '0);
    assign full_o  = (fill == DFULL);
    assign thr_o   = (fill >= DTHR);
    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && !empty_o;
    assign head_o  = mem[rd_ptr];

    // Store an accepted snapshot at the write position.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= data_i;
    end

    // Advance the pointers and track the fill level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            fill <= fill + CNTW'(do_push) - CNTW'(do_pop);
        end
    end

    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= DFULL); // R6
    AST_DROP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full_o && !pop_i) |=> full_o); // R5
    AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && empty_o && !push_i) |=> empty_o); // R7
endmodule

// File: rtl/evt_scaler.sv
// Mapped four-channel event scaler with a pipelined Wishbone slave port.
// Assumes NUM_IN <= 8 (one map byte per counter) and CNT_W <= 32.
module evt_scaler
    import evs_pkg::*;
#(
    parameter int NUM_IN      = EVS_NIN,
    parameter int CNT_W       = EVS_CW,
    parameter int BUF_DEPTH   = 8,
    parameter int BUF_THRESH  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wb_cyc_i,
    input  logic              wb_stb_i,
    input  logic              wb_we_i,
    input  logic [2:0]        wb_adr_i,
    input  logic [31:0]       wb_dat_i,
    output logic [31:0]       wb_dat_o,
    output logic              wb_ack_o,
    output logic              wb_stall_o,
    input  logic [NUM_IN-1:0] ev_in_i
);
    localparam int NCH  = EVS_NCH;
    localparam int NGRP = NCH + 2;
    localparam int GLAT = NCH;
    localparam int GRUN = NCH + 1;
    localparam int PW   = $clog2(NCH);
    localparam int SW   = NCH * CNT_W;

    function automatic logic [31:0] cmap_default();
        logic [31:0] r = '0;
        for (int n = 0; n < NCH; n++) r[8*n + n] = 1'b1;
        return r;
    endfunction

    // Bus decode
    logic acc, wr, rd, ctrl_wr;
    assign acc     = wb_cyc_i && wb_stb_i;
    assign wr      = acc && wb_we_i;
    assign rd      = acc && !wb_we_i;
    assign ctrl_wr = wr && (wb_adr_i == RA_CTRL);
    assign wb_stall_o = 1'b0;

    // Configuration state
    logic [31:0]      cmap;
    logic [8:0]       lmap, smap;
    logic [CNT_W-1:0] limit_q;
    logic             auto_ld, running;

    // Commands decoded from a control write
    logic cnt_clr, sw_start, sw_stop, sw_latch, ld_cur, ld_buf;
    assign cnt_clr  = ctrl_wr && wb_dat_i[CB_EMPTY];
    assign sw_start = ctrl_wr && wb_dat_i[CB_RUN]   && smap[SW_BIT];
    assign sw_stop  = ctrl_wr && wb_dat_i[CB_STOP]  && smap[SW_BIT];
    assign sw_latch = ctrl_wr && wb_dat_i[CB_SWLAT] && lmap[SW_BIT];
    assign ld_cur   = ctrl_wr && wb_dat_i[CB_LDCUR];
    assign ld_buf   = ctrl_wr && wb_dat_i[CB_LDBUF];

    // Synchronized lines and mapped edge detection
    logic [NUM_IN-1:0] sin;
    logic [NUM_IN-1:0] sel [NGRP];
    logic [NGRP-1:0]   lvl, lvl_q, rise;

    evs_sync #(.W(NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(ev_in_i), .q_o(sin)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_cmask
        assign sel[g] = cmap[8*g +: NUM_IN];
    end
    assign sel[GLAT] = lmap[NUM_IN-1:0];
    assign sel[GRUN] = smap[NUM_IN-1:0];

    for (genvar g = 0; g < NGRP; g++) begin : g_edge
        assign lvl[g]  = |(sin & sel[g]);
        assign rise[g] = lvl[g] && !lvl_q[g];
    end

    // Remember the previous level of every mapped OR group.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl;
    end

    // Counters
    logic [NCH-1:0][CNT_W-1:0] cnt;
    logic [NCH-1:0]            ovf;
    for (genvar n = 0; n < NCH; n++) begin : g_cnt
        evs_counter #(.CW(CNT_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .clr_i(cnt_clr),
            .inc_i(running && rise[n]), .limit_i(limit_q),
            .count_o(cnt[n]), .ovf_o(ovf[n])
        );
    end

    // Snapshot buffer
    logic                      latch_ev, f_empty, f_full, f_thr;
    logic [SW-1:0]             head_flat;
    logic [NCH-1:0][CNT_W-1:0] head;
    assign latch_ev = rise[GLAT] || sw_latch;
    assign head     = head_flat;

    evs_snapfifo #(.W(SW), .DEPTH(BUF_DEPTH), .THRESH(BUF_THRESH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push_i(latch_ev), .data_i(cnt),
        .pop_i(ld_buf), .head_o(head_flat),
        .empty_o(f_empty), .full_o(f_full), .thr_o(f_thr)
    );

    // Register writes and the running state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmap    <= cmap_default();
            lmap    <= 9'h010;
            smap    <= 9'h080;
            limit_q <= '1;
            auto_ld <= 1'b0;
            running <= 1'b0;
        end else begin
            if (wr) begin
                case (wb_adr_i)
                    RA_CTRL:  auto_ld <= wb_dat_i[CB_AUTO];
                    RA_CMAP:  cmap    <= wb_dat_i;
                    RA_LMAP:  lmap    <= wb_dat_i[8:0];
                    RA_SMAP:  smap    <= wb_dat_i[8:0];
                    RA_LIMIT: limit_q <= wb_dat_i[CNT_W-1:0];
                    default: ;
                endcase
            end
            if (sw_stop)        running <= 1'b0;
            else if (sw_start)  running <= 1'b1;
            else if (rise[GRUN]) running <= !running;
        end
    end

    // Output holding register and the three read positions.
    logic [NCH-1:0][CNT_W-1:0] outr;
    logic [PW-1:0]             optr, lptr, pptr;
    logic                      out_live, out_buf;
    assign out_live = ld_cur || (auto_ld && latch_ev);
    assign out_buf  = ld_buf && !f_empty;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outr <= '0;
            optr <= '0;
            lptr <= '0;
            pptr <= '0;
        end else begin
            if (out_live) begin
                outr <= cnt;
                optr <= '0;
            end else if (out_buf) begin
                outr <= head;
                optr <= '0;
            end else if (rd && wb_adr_i == RA_OUT) begin
                optr <= optr + 1'b1;
            end
            if (cnt_clr)                      lptr <= '0;
            else if (rd && wb_adr_i == RA_LIVE) lptr <= lptr + 1'b1;
            if (out_buf)                      pptr <= '0;
            else if (rd && wb_adr_i == RA_PEEK) pptr <= pptr + 1'b1;
        end
    end

    // Read data mux, registered with the acknowledge.
    logic [31:0] rdata, ctrl_word;
    always_comb begin
        ctrl_word = '0;
        ctrl_word[CB_EMPTY] = f_empty;
        ctrl_word[CB_FULL]  = f_full;
        ctrl_word[CB_THR]   = f_thr;
        ctrl_word[CB_RUN]   = running;
        ctrl_word[CB_OVF +: NCH] = ovf;
        ctrl_word[CB_AUTO]  = auto_ld;
        case (wb_adr_i)
            RA_CTRL:  rdata = ctrl_word;
            RA_CMAP:  rdata = cmap;
            RA_LMAP:  rdata = {23'd0, lmap};
            RA_SMAP:  rdata = {23'd0, smap};
            RA_LIVE:  rdata = 32'(cnt[lptr]);
            RA_PEEK:  rdata = f_empty ? 32'd0 : 32'(head[pptr]);
            RA_OUT:   rdata = 32'(outr[optr]);
            default:  rdata = 32'(limit_q);
        endcase
    end

    // Acknowledge every accepted request one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_ack_o <= 1'b0;
            wb_dat_o <= '0;
        end else begin
            wb_ack_o <= acc;
            wb_dat_o <= rd ? rdata : 32'd0;
        end
    end

    AST_ACK_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> wb_ack_o); // R2
    AST_ACK_ONLY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> !wb_ack_o); // R2
    AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        sw_stop |=> !running); // R4
    AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (out_live || out_buf) |=> (optr == '0)); // R8
    AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_buf && f_empty && !out_live) |=> $stable(outr)); // R7
endmodule

// File: tb/evt_scaler_test.sv
`timescale 1ns/1ps
module evt_scaler_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc = 1'b0, stb = 1'b0, we = 1'b0;
    logic [2:0]  adr = '0;
    logic [31:0] dat_i = '0;
    logic [31:0] dat_o;
    logic        ack, stall;
    logic [7:0]  ev = '0;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    evt_scaler uut (
        .clk(clk), .rst_n(rst_n), .wb_cyc_i(cyc), .wb_stb_i(stb),
        .wb_we_i(we), .wb_adr_i(adr), .wb_dat_i(dat_i), .wb_dat_o(dat_o),
        .wb_ack_o(ack), .wb_stall_o(stall), .ev_in_i(ev)
    );

    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_PULSE = 2'd2;
    typedef struct packed {
        logic [1:0]  op;
        logic [2:0]  adr;
        logic [31:0] dat;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 34;
    localparam vec_t VEC [NV] = '{
        '{OP_RD, 3'd0, 32'h0000_0001, 4'd1},   // R1 control
        '{OP_RD, 3'd1, 32'h0804_0201, 4'd1},   // R1 counter map
        '{OP_RD, 3'd2, 32'h0000_0010, 4'd1},   // R1 latch map
        '{OP_RD, 3'd3, 32'h0000_0080, 4'd1},   // R1 run map
        '{OP_RD, 3'd7, 32'hFFFF_FFFF, 4'd1},   // R1 full-scale
        '{OP_WR, 3'd0, 32'h0000_0008, 4'd4},   // R4 start while sw gated off
        '{OP_RD, 3'd0, 32'h0000_0001, 4'd4},
        '{OP_WR, 3'd3, 32'h0000_0100, 4'd4},
        '{OP_WR, 3'd2, 32'h0000_0100, 4'd5},
        '{OP_WR, 3'd0, 32'h0000_0008, 4'd4},   // R4 start
        '{OP_RD, 3'd0, 32'h0000_0009, 4'd4},
        '{OP_PULSE, 3'd0, 32'h0000_0001, 4'd3}, // R3 patterns
        '{OP_PULSE, 3'd0, 32'h0000_0003, 4'd3},
        '{OP_PULSE, 3'd0, 32'h0000_000C, 4'd3},
        '{OP_PULSE, 3'd0, 32'h0000_0004, 4'd3},
        '{OP_WR, 3'd1, 32'h0804_0230, 4'd3},
        '{OP_PULSE, 3'd0, 32'h0000_0010, 4'd3},
        '{OP_PULSE, 3'd0, 32'h0000_0030, 4'd3},
        '{OP_RD, 3'd4, 32'd4, 4'd13},           // R13 live view
        '{OP_RD, 3'd4, 32'd1, 4'd13},
        '{OP_RD, 3'd4, 32'd2, 4'd13},
        '{OP_RD, 3'd4, 32'd1, 4'd13},
        '{OP_WR, 3'd0, 32'h0000_0088, 4'd5},   // R5 software latch
        '{OP_RD, 3'd0, 32'h0000_0008, 4'd6},
        '{OP_RD, 3'd5, 32'd4, 4'd13},
        '{OP_WR, 3'd0, 32'h0000_0048, 4'd7},   // R7 pop
        '{OP_RD, 3'd0, 32'h0000_0009, 4'd6},
        '{OP_RD, 3'd6, 32'd4, 4'd8},            // R8 sequence
        '{OP_RD, 3'd6, 32'd1, 4'd8},
        '{OP_RD, 3'd6, 32'd2, 4'd8},
        '{OP_RD, 3'd6, 32'd1, 4'd8},
        '{OP_RD, 3'd6, 32'd4, 4'd8},
        '{OP_WR, 3'd0, 32'h0000_0010, 4'd4},   // R4 stop
        '{OP_RD, 3'd0, 32'h0000_0001, 4'd4}
    };

    task automatic check(input int req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL R%0d: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic bus_op(input logic w, input logic [2:0] a, input logic [31:0] d,
                          output logic [31:0] q);
        @(negedge clk);
        cyc = 1'b1; stb = 1'b1; we = w; adr = a; dat_i = d;
        @(negedge clk);
        cyc = 1'b0; stb = 1'b0; we = 1'b0;
        check(2, {31'd0, ack}, 32'd1);   // R2 ack one cycle after request
        check(2, {31'd0, stall}, 32'd0); // R2 never stalls
        q = dat_o;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        logic [31:0] q;
        bus_op(1'b1, a, d, q);
    endtask

    task automatic rd_chk(input int req, input logic [2:0] a, input logic [31:0] exp);
        logic [31:0] q;
        bus_op(1'b0, a, 32'd0, q);
        check(req, q, exp);
    endtask

    task automatic pulse(input logic [7:0] m);
        @(negedge clk); ev = m;
        repeat (4) @(negedge clk);
        ev = '0;
        repeat (4) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(2, {31'd0, ack}, 32'd0); // R2 no ack without request

        for (int i = 0; i < NV; i++) begin
            case (VEC[i].op)
                OP_WR:    wr(VEC[i].adr, VEC[i].dat);
                OP_RD:    rd_chk(int'(VEC[i].req), VEC[i].adr, VEC[i].dat);
                default:  pulse(VEC[i].dat[7:0]);
            endcase
        end

        // R3 stopped: no counting; R9 load live counts
        pulse(8'h30);
        wr(3'd0, 32'h20);
        rd_chk(9, 3'd6, 32'd4);
        rd_chk(9, 3'd6, 32'd1);

        // R6 threshold at 4, full at 8; R5 ninth latch dropped
        for (int k = 0; k < 4; k++) wr(3'd0, 32'h80);
        rd_chk(6, 3'd0, 32'h04);
        for (int k = 0; k < 4; k++) wr(3'd0, 32'h80);
        rd_chk(6, 3'd0, 32'h06);
        wr(3'd0, 32'h80);
        for (int k = 0; k < 7; k++) wr(3'd0, 32'h40);
        rd_chk(5, 3'd0, 32'h00);
        wr(3'd0, 32'h40);
        rd_chk(5, 3'd0, 32'h01);

        // R10 counter clear
        wr(3'd0, 32'h01);
        for (int k = 0; k < 4; k++) rd_chk(10, 3'd4, 32'd0);

        // R11 wrap at programmed full scale
        wr(3'd1, 32'h0804_0201);
        wr(3'd7, 32'd2);
        wr(3'd0, 32'h08);
        for (int k = 0; k < 3; k++) pulse(8'h01);
        rd_chk(11, 3'd0, 32'h109);
        rd_chk(11, 3'd4, 32'd0);
        wr(3'd0, 32'h09);
        rd_chk(10, 3'd0, 32'h09);

        // R5 hardware latch from line 6
        wr(3'd7, 32'hFFFF_FFFF);
        pulse(8'h02);
        pulse(8'h02);
        wr(3'd2, 32'h040);
        pulse(8'h40);
        rd_chk(5, 3'd0, 32'h08);
        wr(3'd0, 32'h48);
        rd_chk(5, 3'd6, 32'd0);
        rd_chk(5, 3'd6, 32'd2);

        // R4 hardware toggle on line 7, stop wins over start
        wr(3'd3, 32'h180);
        pulse(8'h80);
        rd_chk(4, 3'd0, 32'h01);
        pulse(8'h80);
        rd_chk(4, 3'd0, 32'h09);
        wr(3'd0, 32'h18);
        rd_chk(4, 3'd0, 32'h01);

        // R12 auto-load on latch
        wr(3'd0, 32'h1008);
        rd_chk(12, 3'd0, 32'h1009);
        pulse(8'h04);
        wr(3'd2, 32'h100);
        wr(3'd0, 32'h1080);
        rd_chk(12, 3'd6, 32'd0);
        rd_chk(12, 3'd6, 32'd2);
        rd_chk(12, 3'd6, 32'd1);
        rd_chk(12, 3'd0, 32'h1008);

        // R7 pop, then pop on empty leaves output and position alone
        wr(3'd0, 32'h1040);
        rd_chk(7, 3'd6, 32'd0);
        wr(3'd0, 32'h1040);
        rd_chk(7, 3'd6, 32'd2);
        rd_chk(13, 3'd5, 32'd0); // R13 peek on empty reads 0

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule